// File: doc/BRIEF.md
# Flash Erase Sequencer

This block is a host-side controller for a parallel NOR flash bus. It erases one or more sectors, or the whole array, from a single start pulse. When started, it sends the five-write command prefix (unlock, unlock, set-up, unlock, unlock) and then the erase command. In sector mode it then writes every further sector of the request list, keeping an even spacing between writes. Each further write must fall inside the window in which the device still accepts more sectors.

Once the last command is written, the sequencer does only status reads. It first waits until the device reports that the acceptance window has closed. It then toggle-polls data bit 6 until two reads agree. A poll budget catches an erase that never finishes. If the device sees a hardware reset, the command sequence restarts from the first unlock write as soon as the device reports ready again.

The sector list lives in a small register file outside the block. The block selects an entry with `req_idx`, and the register file returns that entry's flash address on `sec_addr` in the same cycle.

Top module: `flash_erase_seq`

## Requirements
- R1: During and after reset, `busy`, `done`, `err`, `f_we` and `f_oe` are low and `err_code` is 0.
- R2: An accepted start issues, with one-cycle `f_we` strobes spaced exactly WR_GAP+1 cycles apart, the writes 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h. These are followed by the erase command: list entry 0 with data 30h in sector mode (`chip_mode`=0), or 555h with data 10h in chip mode.
- R3: In sector mode, list entries 1 to `sec_count`-1 are each written with data 30h, in index order and at the same spacing.
- R4: If the next sector command would come more than WIN_CYC cycles after the previous sector command strobe, it is not written. Instead `err` pulses with `err_code` 1 and the block goes idle. A spacing equal to WIN_CYC is accepted.
- R5: After the last sector command, the block reads status (`f_oe` high, one read per cycle) until data bit 3 reads 1. Chip mode skips this phase.
- R6: Next the block reads status every cycle. `done` pulses for one cycle, with `busy` already low, once two consecutive reads in this phase return the same data bit 6.
- R7: If TMO_CYC status reads pass without completion, `err` pulses with `err_code` 2, no further read is made and the block goes idle.
- R8: A sector-mode start with `sec_count` 0 makes no bus access and pulses `err` with `err_code` 3 in the cycle after the start.
- R9: `f_rst_evt` while busy stops all strobes from the next cycle. The block waits for `f_rdy` high and then reissues the whole sequence from the first unlock write.
- R10: While busy, `start` is ignored. No write strobe occurs during polling, and `f_we` and `f_oe` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted when idle |
| chip_mode | input | 1 | 1: whole-array erase, 0: sector list erase |
| sec_count | input | clog2(SECT_N+1) | Number of list entries to erase |
| req_idx | output | clog2(SECT_N) | Index of the list entry being fetched |
| sec_addr | input | ADDR_W | Flash address of the entry at `req_idx` |
| f_addr | output | ADDR_W | Flash bus address |
| f_dout | output | 8 | Flash bus write data |
| f_din | input | 8 | Flash bus read data (status) |
| f_we | output | 1 | Write strobe, one cycle per bus write |
| f_oe | output | 1 | Read strobe, data sampled at the end of the cycle |
| f_rdy | input | 1 | Device ready indication |
| f_rst_evt | input | 1 | Pulse: the device saw a hardware reset |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | One-cycle pulse on abort |
| err_code | output | 2 | Reason of the last abort, held until the next start |

## Verification
The main instance uses ADDR_W 16, SECT_N 8, WR_GAP 3, WIN_CYC 4 and TMO_CYC 40. With these values the sector spacing sits exactly on the window limit, so every multi-sector run tests the accepted boundary. The full eight-entry list and the timeout also complete within a few dozen cycles. A second instance uses WR_GAP 4 with WIN_CYC 4, one cycle over the limit, so the window abort after the first sector command becomes reachable. A behavioural device model in the bench makes bit 6 toggle only once the window has closed. Because of this, a sequencer that skips the bit-3 phase, or that ends toggle polling early, stops while the model still reports an erase in progress.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int ADDR_W  = 23,
  parameter int SECT_N  = 16,
  parameter int WR_GAP  = 2,
  parameter int WIN_CYC = 6250,
  parameter int TMO_CYC = 1000000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        chip_mode,
  input  logic [$clog2(SECT_N+1)-1:0] sec_count,
  output logic [$clog2(SECT_N)-1:0]   req_idx,
  input  logic [ADDR_W-1:0]           sec_addr,
  output logic [ADDR_W-1:0]           f_addr,
  output logic [7:0]                  f_dout,
  input  logic [7:0]                  f_din,
  output logic                        f_we,
  output logic                        f_oe,
  input  logic                        f_rdy,
  input  logic                        f_rst_evt,
  output logic                        busy,
  output logic                        done,
  output logic                        err,
  output logic [1:0]                  err_code
);
  localparam int IW = $clog2(SECT_N);
  localparam int CW = $clog2(SECT_N + 1);
  localparam int GW = $clog2(WR_GAP + 1) + 1;
  localparam int WW = $clog2(WIN_CYC + 1) + 1;
  localparam int TW = $clog2(TMO_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_GAP, S_WIN, S_TOG, S_REC} st_t;

  st_t           st;
  logic [2:0]    step;
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;
  logic          chip;
  logic [GW-1:0] gap;
  logic [WW-1:0] win;
  logic [TW-1:0] polls;
  logic          prev6, have6;

  wire extra     = (step == 3'd5) && !chip && (idx != '0);
  wire win_bad   = (st == S_WR) && extra && (win >= WW'(WIN_CYC));
  wire last_wr   = (step == 3'd5) && (chip || ((CW'(idx) + CW'(1)) == cnt));
  wire tog_done  = (st == S_TOG) && have6 && (f_din[6] == prev6);
  wire poll_last = (polls == TW'(TMO_CYC - 1));

  assign busy    = (st != S_IDLE);
  assign req_idx = idx;
  assign f_we    = (st == S_WR) && !win_bad;
  assign f_oe    = (st == S_WIN) || (st == S_TOG);

  always_comb begin
    case (step)
      3'd0:    begin f_addr = ADDR_W'(12'h555); f_dout = 8'hAA; end
      3'd1:    begin f_addr = ADDR_W'(12'h2AA); f_dout = 8'h55; end
      3'd2:    begin f_addr = ADDR_W'(12'h555); f_dout = 8'h80; end
      3'd3:    begin f_addr = ADDR_W'(12'h555); f_dout = 8'hAA; end
      3'd4:    begin f_addr = ADDR_W'(12'h2AA); f_dout = 8'h55; end
      default: begin
        f_addr = chip ? ADDR_W'(12'h555) : sec_addr;
        f_dout = chip ? 8'h10 : 8'h30;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; step <= '0; idx <= '0; cnt <= '0; chip <= 1'b0;
      gap <= '0; win <= '0; polls <= '0; prev6 <= 1'b0; have6 <= 1'b0;
      done <= 1'b0; err <= 1'b0; err_code <= 2'd0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (win < WW'(WIN_CYC)) win <= win + WW'(1);
      if (f_rst_evt && busy) begin
        st <= S_REC;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            err_code <= 2'd0; chip <= chip_mode; cnt <= sec_count;
            step <= '0; idx <= '0; polls <= '0; win <= '0;
            if (!chip_mode && sec_count == '0) begin
              err <= 1'b1; err_code <= 2'd3;
            end else st <= S_WR;
          end
          S_WR: begin
            if (win_bad) begin
              st <= S_IDLE; err <= 1'b1; err_code <= 2'd1;
            end else begin
              if (step == 3'd5 && !chip) win <= '0;
              if (last_wr) begin
                st <= chip ? S_TOG : S_WIN; have6 <= 1'b0; polls <= '0;
              end else begin
                if (step != 3'd5) step <= step + 3'd1;
                else idx <= idx + IW'(1);
                gap <= '0;
                st  <= (WR_GAP == 0) ? S_WR : S_GAP;
              end
            end
          end
          S_GAP: begin
            if (int'(gap) + 1 >= WR_GAP) st <= S_WR;
            else gap <= gap + GW'(1);
          end
          S_WIN, S_TOG: begin
            if (tog_done) begin
              st <= S_IDLE; done <= 1'b1;
            end else if (poll_last) begin
              st <= S_IDLE; err <= 1'b1; err_code <= 2'd2;
            end else begin
              polls <= polls + TW'(1);
              if (st == S_WIN) begin
                if (f_din[3]) st <= S_TOG;
              end else begin
                prev6 <= f_din[6]; have6 <= 1'b1;
              end
            end
          end
          S_REC: if (f_rdy) begin
            st <= S_WR; step <= '0; idx <= '0; polls <= '0; win <= '0;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(f_we && f_oe));
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  // R4
  err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (err_code != 2'd0));
  // R9
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_rst_evt && busy) |=> (!f_we && !f_oe));
endmodule

// File: tb/flash_erase_seq_bench.sv
module flash_erase_seq_bench;
  localparam int ADDR_W = 16, SECT_N = 8, WR_GAP = 3, WIN_CYC = 4, TMO_CYC = 40;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        start_a = 1'b0, chip_a = 1'b0, start_b = 1'b0;
  logic [3:0]  cnt_a = '0, cnt_b = '0;
  logic        f_rdy = 1'b1, f_rst_evt = 1'b0;
  logic [15:0] tab [SECT_N];

  logic [2:0]  idx_a, idx_b;
  logic [15:0] addr_a, addr_b;
  logic [7:0]  dout_a, dout_b, din_a;
  logic        we_a, oe_a, busy_a, done_a, err_a;
  logic        we_b, oe_b, busy_b, done_b, err_b;
  logic [1:0]  code_a, code_b;

  flash_erase_seq #(.ADDR_W(ADDR_W), .SECT_N(SECT_N), .WR_GAP(WR_GAP),
                    .WIN_CYC(WIN_CYC), .TMO_CYC(TMO_CYC)) u_flash_erase_seq (
    .clk(clk), .rst_n(rst_n), .start(start_a), .chip_mode(chip_a), .sec_count(cnt_a),
    .req_idx(idx_a), .sec_addr(tab[idx_a]), .f_addr(addr_a), .f_dout(dout_a),
    .f_din(din_a), .f_we(we_a), .f_oe(oe_a), .f_rdy(f_rdy), .f_rst_evt(f_rst_evt),
    .busy(busy_a), .done(done_a), .err(err_a), .err_code(code_a));

  flash_erase_seq #(.ADDR_W(ADDR_W), .SECT_N(SECT_N), .WR_GAP(4),
                    .WIN_CYC(4), .TMO_CYC(TMO_CYC)) u_win_over (
    .clk(clk), .rst_n(rst_n), .start(start_b), .chip_mode(1'b0), .sec_count(cnt_b),
    .req_idx(idx_b), .sec_addr(tab[idx_b]), .f_addr(addr_b), .f_dout(dout_b),
    .f_din(8'h00), .f_we(we_b), .f_oe(oe_b), .f_rdy(1'b1), .f_rst_evt(1'b0),
    .busy(busy_b), .done(done_b), .err(err_b), .err_code(code_b));

  // behavioural device: bit 3 = window closed, bit 6 toggles per read once erasing past the window
  int close_ctr = 0, tog_left = 0, post_reads = 0, dev_toggles = 5;
  bit erasing = 1'b0, tog = 1'b0;
  assign din_a = {1'b0, tog, 2'b00, (close_ctr == 0), 3'b000};

  always @(posedge clk) begin
    if (f_rst_evt) begin
      erasing <= 1'b0; close_ctr <= 0;
    end else begin
      if (close_ctr > 0) close_ctr <= close_ctr - 1;
      if (we_a && (dout_a == 8'h30 || dout_a == 8'h10)) begin
        erasing <= 1'b1; tog_left <= dev_toggles; post_reads <= 0;
        close_ctr <= (dout_a == 8'h10) ? 0 : 6;
      end else if (oe_a) begin
        if (!erasing) post_reads <= post_reads + 1;
        else if (close_ctr == 0) begin
          tog <= ~tog;
          if (tog_left <= 1) erasing <= 1'b0;
          tog_left <= tog_left - 1;
        end
      end
    end
  end

  int compared = 0, mismatched = 0, cyc = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference write stream
  logic [23:0] exp_q[$];
  bit flush_req = 1'b0, seen_we = 1'b0, last_chip = 1'b0;
  int since_we = 0, rd_cnt = 0, wr_b = 0, last_n = 0;

  task automatic push_seq(bit chipm, int n);
    exp_q.push_back({16'h0555, 8'hAA}); exp_q.push_back({16'h02AA, 8'h55});
    exp_q.push_back({16'h0555, 8'h80}); exp_q.push_back({16'h0555, 8'hAA});
    exp_q.push_back({16'h02AA, 8'h55});
    if (chipm) exp_q.push_back({16'h0555, 8'h10});
    else for (int i = 0; i < n; i++) exp_q.push_back({tab[i], 8'h30});
    last_chip = chipm; last_n = n;
  endtask

  always @(negedge clk) if (rst_n) begin
    logic [23:0] e;
    if (start_a && !busy_a) begin seen_we = 1'b0; rd_cnt = 0; end
    if (start_b && !busy_b) wr_b = 0;
    chk(!(we_a && oe_a), "R10", "write and read strobe together", int'(we_a & oe_a), 0);
    if (oe_a) rd_cnt++;
    if (we_b) wr_b++;
    if (we_a) begin
      if (exp_q.size() == 0) chk(1'b0, "R10", "unexpected write, data", int'(dout_a), -1);
      else begin
        e = exp_q.pop_front();
        chk(addr_a == e[23:8] && dout_a == e[7:0], "R2/R3", "write addr,data",
            int'({addr_a, dout_a}), int'(e));
      end
      if (seen_we) chk(since_we == WR_GAP + 1, "R2", "strobe spacing", since_we, WR_GAP + 1);
      since_we = 1; seen_we = 1'b1;
    end else since_we++;
    if (flush_req) begin
      exp_q.delete(); push_seq(last_chip, last_n); flush_req = 1'b0; seen_we = 1'b0;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic go_a(bit chipm, int n);
    @(posedge clk); #2;
    chip_a = chipm; cnt_a = 4'(n); start_a = 1'b1;
    @(posedge clk); #2;
    start_a = 1'b0;
  endtask

  task automatic wait_end(string req);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done_a || err_a) return;
    end
    chk(1'b0, req, "no completion", 0, 1);
  endtask

  task automatic check_ok(string req);
    chk(done_a && !err_a, req, "done pulse", int'(done_a), 1);
    chk(!busy_a, req, "busy low with done", int'(busy_a), 0);
    chk(!erasing, req, "device still erasing at done", int'(erasing), 0);
    chk(post_reads <= 2, req, "reads after device finished", post_reads, 2);
    chk(exp_q.size() == 0, req, "writes outstanding", exp_q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < SECT_N; i++) tab[i] = 16'(16'h0800 * i + 16'h0123);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy_a && !done_a && !err_a && !we_a && !oe_a && code_a == 0, "R1",
        "outputs in reset", int'({busy_a, done_a, err_a, we_a, oe_a, code_a}), 0);
    @(posedge clk); #2; rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_a && !we_a && !oe_a && code_a == 0, "R1", "outputs after reset",
        int'({busy_a, we_a, oe_a, code_a}), 0);

    // R2 R5 R6: single sector
    push_seq(1'b0, 1); go_a(1'b0, 1); wait_end("R6"); check_ok("R5");
    // R3: four sectors at the window limit spacing (R4 accepted boundary)
    push_seq(1'b0, 4); go_a(1'b0, 4); wait_end("R3"); check_ok("R3");
    chk(code_a == 0, "R4", "spacing equal to window rejected", code_a, 0);
    // R3: full list
    push_seq(1'b0, SECT_N); go_a(1'b0, SECT_N); wait_end("R3"); check_ok("R3");
    // R2: chip mode
    push_seq(1'b1, 0); go_a(1'b1, 0); wait_end("R2"); check_ok("R2");

    // R8: empty list
    go_a(1'b0, 0);
    @(negedge clk);
    chk(err_a && code_a == 2'd3, "R8", "empty list err,code", int'({err_a, code_a}), 7);
    chk(!busy_a, "R8", "busy after empty list", int'(busy_a), 0);
    repeat (3) @(negedge clk);

    // R10: start while busy is ignored
    push_seq(1'b0, 2); go_a(1'b0, 2);
    repeat (3) @(posedge clk);
    #2; chip_a = 1'b1; cnt_a = 4'd5; start_a = 1'b1;
    @(posedge clk); #2; start_a = 1'b0;
    wait_end("R10"); check_ok("R10");

    // R7: stuck erase
    dev_toggles = 1000;
    push_seq(1'b0, 1); go_a(1'b0, 1); wait_end("R7");
    chk(err_a && code_a == 2'd2, "R7", "timeout err,code", int'({err_a, code_a}), 6);
    chk(rd_cnt == TMO_CYC, "R7", "status reads before timeout", rd_cnt, TMO_CYC);
    @(negedge clk);
    chk(!oe_a && !busy_a, "R7", "activity after timeout", int'({oe_a, busy_a}), 0);
    dev_toggles = 5;

    // R9: hardware reset during the command writes
    push_seq(1'b0, 3); go_a(1'b0, 3);
    repeat (8) @(posedge clk);
    #2; f_rst_evt = 1'b1; f_rdy = 1'b0; flush_req = 1'b1;
    @(posedge clk); #2; f_rst_evt = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!we_a && !oe_a && busy_a, "R9", "strobes while waiting for ready",
          int'({we_a, oe_a, busy_a}), 1);
    end
    @(posedge clk); #2; f_rdy = 1'b1;
    wait_end("R9"); check_ok("R9");

    // R4: second instance, spacing one cycle over the window
    @(posedge clk); #2; cnt_b = 4'd3; start_b = 1'b1;
    @(posedge clk); #2; start_b = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (err_b || done_b) break;
    end
    chk(err_b && code_b == 2'd1, "R4", "window err,code", int'({err_b, code_b}), 5);
    chk(wr_b == 6, "R4", "writes before window abort", wr_b, 6);
    @(negedge clk);
    chk(!busy_b && !we_b, "R4", "idle after window abort", int'({busy_b, we_b}), 0);

    repeat (5) @(negedge clk);
    summary();
  end
endmodule